// File: doc/BRIEF.md
# Shadowed Configuration Store Controller

This block keeps a configuration word in three layers so that user logic can keep running on one image while the next is prepared behind it. Bits arrive one per clock on a serial input into a staging shift register. A commit strobe, accepted only when exactly one word's worth of bits has been shifted since the last commit, writes the staged word into a persistent shadow store after a programming delay. The live register that drives the user logic is untouched until a separate activate strobe starts a timed swap window. During that window the pins are released (output enable low), and at its end the shadow image is copied into the live register.

The shadow store is not cleared by the power-on reset. Releasing reset runs the same timed swap as an activate, so an image that was committed but never activated becomes live after the next power cycle. A blank part starts with all layers at zero. When several strobes arrive together while idle, activate wins over commit and commit wins over shift; the losers are dropped.

Top module: `cfg_shadow_ctrl`

## Requirements
- R1: While idle, each cycle with `shift_en` high shifts `sin` into bit 0 of the staging register, older bits moving toward the MSB, so the first bit shifted ends up in bit WIDTH-1; shifting never changes `cfg_out`.
- R2: A `commit` while idle, after exactly WIDTH shifts, raises `busy` for PROG_CYCLES cycles starting the next cycle; in the cycle after that `busy` falls, `pend` rises and the shadow holds the staged word, while `cfg_out` is unchanged throughout.
- R3: An `activate` while idle drives `pins_oe` low for exactly SWAP_CYCLES cycles starting the next cycle; in the following cycle `pins_oe` is high, `busy` is low and `cfg_out` equals the shadow image.
- R4: Completion of a swap clears `pend`, and a new pattern may be staged, committed and activated right after, for any number of patterns in turn.
- R5: `busy` is high during a commit or a swap; `pins_oe` is low only while a swap is running.
- R6: `cfg_out` changes only in the cycle in which `pins_oe` returns high; it never shows a partly shifted value.
- R7: After `por_n` is released, `pins_oe` stays low for SWAP_CYCLES cycles (counted from the first clock edge with `por_n` high) and `cfg_out` then equals the shadow image, which survives the reset; from blank this is all zeros.
- R8: A `shift_en`, `commit` or `activate` that arrives while `busy` has no effect on any layer or on the bit count, and sets the sticky `err`, which only `por_n` clears.
- R9: A `commit` after a bit count other than WIDTH is rejected: no busy period, `pend` and the shadow unchanged, `err` set, and the bit count restarts from zero.
- R10: While `por_n` is low, `pins_oe` is low, `busy` is high, and `err`, `pend` and `cfg_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sin | input | 1 | Serial configuration data |
| shift_en | input | 1 | Shift `sin` into the staging register |
| commit | input | 1 | Store the staged word into the shadow |
| activate | input | 1 | Start the swap from shadow to live |
| cfg_out | output | WIDTH | Live configuration to the user logic |
| pins_oe | output | 1 | User pin drive enable; low releases the pins |
| busy | output | 1 | Commit or swap in progress |
| err | output | 1 | Sticky request-while-busy or bad-commit flag |
| pend | output | 1 | Shadow holds an image not yet activated |

## Verification
A strobe driven before clock edge N takes effect at N: a rejected commit or a request made while busy shows in `err` one cycle later, the commit busy period ends and `pend` rises PROG_CYCLES+1 cycles after the commit, and the new `cfg_out` with `pins_oe` high appears SWAP_CYCLES+1 cycles after an activate, or SWAP_CYCLES cycles after reset release. Each driver task records these due cycles with the expected values in a scoreboard queue, and a monitor compares them on the falling edge of exactly that cycle. Checks are placed just before and at each boundary, so a window that is one cycle long or short is caught. Ignored requests are confirmed by reading the live image after a later swap and by a following exact-width commit still being accepted.

// File: rtl/cfg_shadow_ctrl.sv
module cfg_shadow_ctrl #(
  parameter int WIDTH       = 16,
  parameter int SWAP_CYCLES = 6250,
  parameter int PROG_CYCLES = 64
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sin,
  input  logic             shift_en,
  input  logic             commit,
  input  logic             activate,
  output logic [WIDTH-1:0] cfg_out,
  output logic             pins_oe,
  output logic             busy,
  output logic             err,
  output logic             pend
);
  localparam int CW   = $clog2(WIDTH + 2);
  localparam int TMAX = (SWAP_CYCLES > PROG_CYCLES) ? SWAP_CYCLES : PROG_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_PROG, S_SWAP} state_t;

  state_t           st;
  logic [TW-1:0]    tmr;
  logic [CW-1:0]    nbits;
  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] shadow = '0;
  logic [WIDTH-1:0] live;

  wire any_req   = shift_en | commit | activate;
  wire prog_done = (st == S_PROG) && (tmr == TW'(PROG_CYCLES - 1));
  wire swap_done = (st == S_SWAP) && (tmr == TW'(SWAP_CYCLES - 1));

  assign cfg_out = live;
  assign busy    = (st != S_IDLE);
  assign pins_oe = (st != S_SWAP);

  always_ff @(posedge clk)
    if (prog_done) shadow <= stage;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st    <= S_SWAP;
      tmr   <= '0;
      nbits <= '0;
      stage <= '0;
      live  <= '0;
      pend  <= 1'b0;
      err   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (activate) begin
            st  <= S_SWAP;
            tmr <= '0;
          end else if (commit) begin
            nbits <= '0;
            if (nbits == CW'(WIDTH)) begin
              st  <= S_PROG;
              tmr <= '0;
            end else begin
              err <= 1'b1;
            end
          end else if (shift_en) begin
            stage <= {stage[WIDTH-2:0], sin};
            if (nbits != CW'(WIDTH + 1)) nbits <= nbits + 1'b1;
          end
        end
        S_PROG: begin
          if (any_req) err <= 1'b1;
          if (prog_done) begin
            st   <= S_IDLE;
            pend <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (any_req) err <= 1'b1;
          if (swap_done) begin
            st   <= S_IDLE;
            live <= shadow;
            pend <= 1'b0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_shadow_ctrl_chk.sv
module cfg_shadow_ctrl_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             shift_en,
  input logic             commit,
  input logic             activate,
  input logic [WIDTH-1:0] cfg_out,
  input logic             pins_oe,
  input logic             busy,
  input logic             err,
  input logic             pend
);
  AST_CFG_ONLY_AT_SWAP_END: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(cfg_out) |-> $rose(pins_oe)); // R6

  AST_RELEASE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    !pins_oe |-> busy); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    err |=> err); // R8

  AST_BUSY_REQ_FLAGS_ERR: assert property (@(posedge clk) disable iff (!por_n)
    (busy && (shift_en || commit || activate)) |=> err); // R8

  AST_PEND_CLEAR_ON_SWAP: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pins_oe) |-> !pend); // R4

  AST_STORE_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pend) |-> $stable(cfg_out)); // R2
endmodule

bind cfg_shadow_ctrl cfg_shadow_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .por_n(por_n), .shift_en(shift_en), .commit(commit),
  .activate(activate), .cfg_out(cfg_out), .pins_oe(pins_oe),
  .busy(busy), .err(err), .pend(pend)
);

// File: tb/tb_cfg_shadow_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_shadow_ctrl;
  localparam int W  = 8;
  localparam int SW = 12;
  localparam int PC = 3;
  localparam int K_CFG = 0, K_OE = 1, K_BUSY = 2, K_ERR = 3, K_PEND = 4;

  logic clk = 1'b0;
  logic por_n = 1'b0, sin = 1'b0, shift_en = 1'b0, commit = 1'b0, activate = 1'b0;
  logic [W-1:0] cfg_out;
  logic pins_oe, busy, err, pend;

  cfg_shadow_ctrl #(.WIDTH(W), .SWAP_CYCLES(SW), .PROG_CYCLES(PC)) dut (
    .clk(clk), .por_n(por_n), .sin(sin), .shift_en(shift_en), .commit(commit),
    .activate(activate), .cfg_out(cfg_out), .pins_oe(pins_oe), .busy(busy),
    .err(err), .pend(pend)
  );

  always #4 clk = ~clk;

  typedef struct {
    int           due;
    int           sel;
    logic [W-1:0] val;
    string        req;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dly, int sel, logic [W-1:0] val, string req);
    item_t it;
    it.due = cyc + dly; it.sel = sel; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  function automatic logic [W-1:0] observe(int sel);
    case (sel)
      K_CFG:   return cfg_out;
      K_OE:    return {{(W-1){1'b0}}, pins_oe};
      K_BUSY:  return {{(W-1){1'b0}}, busy};
      K_ERR:   return {{(W-1){1'b0}}, err};
      default: return {{(W-1){1'b0}}, pend};
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [W-1:0] act;
        act = observe(q[i].sel);
        checks++;
        if (act !== q[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d signal %0d: actual %h expected %h",
                   q[i].req, cyc, q[i].sel, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic shift_bits(logic [W-1:0] w, int n, logic [W-1:0] live);
    for (int i = n - 1; i >= 0; i--) begin
      sin = w[i]; shift_en = 1'b1;
      expect_at(1, K_CFG, live, "R1");
      step();
    end
    shift_en = 1'b0;
  endtask

  task automatic do_commit(logic [W-1:0] live);
    commit = 1'b1;
    expect_at(1, K_BUSY, 1, "R2");
    expect_at(PC, K_BUSY, 1, "R2");
    expect_at(PC, K_PEND, 0, "R2");
    expect_at(PC + 1, K_BUSY, 0, "R2");
    expect_at(PC + 1, K_PEND, 1, "R2");
    expect_at(PC + 1, K_CFG, live, "R2");
    step();
    commit = 1'b0;
    repeat (PC + 1) step();
  endtask

  task automatic do_activate(logic [W-1:0] old_v, logic [W-1:0] new_v);
    activate = 1'b1;
    expect_at(1, K_OE, 0, "R3");
    expect_at(1, K_BUSY, 1, "R5");
    expect_at(SW, K_OE, 0, "R3");
    expect_at(SW, K_CFG, old_v, "R6");
    expect_at(SW + 1, K_OE, 1, "R3");
    expect_at(SW + 1, K_BUSY, 0, "R3");
    expect_at(SW + 1, K_CFG, new_v, "R3");
    expect_at(SW + 1, K_PEND, 0, "R4");
    step();
    activate = 1'b0;
    repeat (SW + 1) step();
  endtask

  task automatic release_reset(logic [W-1:0] img);
    por_n = 1'b1;
    expect_at(SW - 1, K_OE, 0, "R7");
    expect_at(SW, K_OE, 1, "R7");
    expect_at(SW, K_CFG, img, "R7");
    expect_at(SW, K_ERR, 0, "R7");
    expect_at(SW, K_PEND, 0, "R7");
    repeat (SW + 1) step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) step();
    expect_at(1, K_OE, 0, "R10");
    expect_at(1, K_BUSY, 1, "R10");
    expect_at(1, K_ERR, 0, "R10");
    expect_at(1, K_PEND, 0, "R10");
    expect_at(1, K_CFG, 0, "R10");
    step();
    step();
    release_reset(8'h00);

    shift_bits(8'hA5, W, 8'h00);
    do_commit(8'h00);
    do_activate(8'h00, 8'hA5);

    shift_bits(8'h3C, W, 8'hA5);
    do_commit(8'hA5);
    do_activate(8'hA5, 8'h3C);
    shift_bits(8'hF0, W, 8'h3C);
    do_commit(8'h3C);
    do_activate(8'h3C, 8'hF0);

    expect_at(1, K_ERR, 0, "R9");
    step();
    shift_bits(8'h11, W - 1, 8'hF0);
    commit = 1'b1;
    expect_at(1, K_BUSY, 0, "R9");
    expect_at(1, K_ERR, 1, "R9");
    expect_at(1, K_PEND, 0, "R9");
    step();
    commit = 1'b0;
    do_activate(8'hF0, 8'hF0);

    shift_bits(8'h81, W, 8'hF0);
    do_commit(8'hF0);
    por_n = 1'b0;
    expect_at(1, K_OE, 0, "R10");
    expect_at(1, K_CFG, 0, "R10");
    expect_at(1, K_ERR, 0, "R10");
    step();
    step();
    release_reset(8'h81);

    activate = 1'b1;
    step();
    activate = 1'b0;
    repeat (3) step();
    shift_en = 1'b1; sin = 1'b1;
    expect_at(1, K_ERR, 1, "R8");
    step();
    shift_en = 1'b0;
    commit = 1'b1;
    step();
    commit = 1'b0;
    repeat (SW) step();
    expect_at(1, K_CFG, 8'h81, "R8");
    expect_at(1, K_PEND, 0, "R8");
    expect_at(1, K_ERR, 1, "R8");
    step();
    shift_bits(8'h5A, W, 8'h81);
    do_commit(8'h81);
    do_activate(8'h81, 8'h5A);

    repeat (2) step();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending items expected 0", q.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule